// File: doc/BRIEF.md
# PHY Test-Port Register Access Engine

This block carries out one register access on the serial test port of a D-PHY style receiver. That port has four signals: a test clock, a test enable, a byte-wide test data input and a byte-wide test data output. The PHY reports its test data output inside a 16-bit status word. A requester supplies an address byte, a data byte and an address-only flag. The block then plays out the edge sequence on the port. The address is taken by the PHY on a falling test-clock edge while enable is high. The data is taken on the rising edge that follows, with enable low. The block does not know which registers the PHY holds. Chaining several accesses is the requester's job.

The access runs as a chain of named states. IDLE moves to CLK_RISE when a request arrives. CLK_RISE raises the test clock and nothing else. ADDR_SET raises enable and puts the address on the data input. ADDR_FALL drops the test clock. After ADDR_FALL the block goes to DONE when the access skips its data phase. Otherwise it goes to DATA_SET, which drops enable and puts the data byte on the data input. DATA_RISE then raises the test clock, and the block goes to DONE. DONE lasts one cycle, pulses the acknowledge and returns to IDLE.

Each phase from CLK_RISE to DATA_RISE is held for a programmable number of system clocks, so that the PHY's setup and hold times are met. The byte the PHY returns is captured as the access completes.

Top module: `phy_tst_xactor`

## Requirements
- R1: After reset the test clock and test enable are low, the test data input is 0x00, busy and ack are low and the captured byte is 0x00.
- R2: The first phase of an access raises the test clock. Test enable and the test data input keep the values the previous access left on them.
- R3: In the second phase test enable is high and the address is on the test data input, with the test clock still high. In the third phase the test clock falls while enable and the address are held.
- R4: For a write, the fourth phase drives enable low and puts the data byte on the test data input with the clock low. The fifth phase raises the test clock while enable and data are held.
- R5: When the data byte is 0xFF or the address-only flag is set, the access ends after the third phase. The test clock is then left low, enable high and the address still on the test data input.
- R6: When the access completes, the captured byte takes bits 15:8 of the status word. It is valid in the acknowledge cycle and holds its value until the next access completes.
- R7: Each phase lasts `step_len` system clocks, and a value of 0 counts as 1. `step_len` is sampled when the request is accepted. The acknowledge comes phases×step cycles after the accepting edge.
- R8: busy goes high on the accepting edge and stays high through the acknowledge. ack is a one-cycle pulse, and busy is low in the cycle after it.
- R9: A request presented while busy is ignored. Between accesses the test signals hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start an access (taken only when idle) |
| req_addr | input | 8 | PHY register address |
| req_data | input | 8 | Data byte; 0xFF suppresses the data phase |
| req_addr_only | input | 1 | Address-only access, no data phase |
| step_len | input | 4 | System clocks per phase (0 treated as 1) |
| tst_status | input | 16 | PHY status word; returned byte in bits 15:8 |
| busy | output | 1 | Access in progress |
| ack | output | 1 | One-cycle completion pulse |
| rd_byte | output | 8 | Captured returned byte |
| tst_clk | output | 1 | Test clock to the PHY |
| tst_en | output | 1 | Test enable to the PHY |
| tst_din | output | 8 | Test data input to the PHY |

## Verification
The bench builds the block with its default parameters: byte-wide addresses and data, a 16-bit status word and a 4-bit phase length. Phase lengths of 0, 1, 2, 3 and 4 are therefore all in range, and so is a change to 7 in the middle of an access. This lets the bench check the phase-length sampling and the rule that 0 counts as 1. Every access is traced cycle by cycle against the phase the bench expects. Both ways of skipping the data phase are covered. So is an access that starts with enable left high, and so is a request made while busy.

// File: rtl/phy_tst_pkg.sv
package phy_tst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_CLK_RISE  = 3'd1,
        ST_ADDR_SET  = 3'd2,
        ST_ADDR_FALL = 3'd3,
        ST_DATA_SET  = 3'd4,
        ST_DATA_RISE = 3'd5,
        ST_DONE      = 3'd6
    } tst_state_e;

endpackage

// File: rtl/phy_tst_dwell.sv
module phy_tst_dwell #(
    parameter int DWELL_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [DWELL_W-1:0] len,
    output logic               expired
);
    localparam logic [DWELL_W-1:0] ONE = DWELL_W'(1);

    logic [DWELL_W-1:0] cnt_q;
    logic [DWELL_W-1:0] len_eff;

    assign len_eff = (len == '0) ? ONE : len;
    assign expired = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len_eff - ONE;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end
endmodule

// File: rtl/phy_tst_pins.sv
module phy_tst_pins
    import phy_tst_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter,
    input  tst_state_e       phase,
    input  logic [BUS_W-1:0] addr,
    input  logic [BUS_W-1:0] data,
    output logic             tst_clk,
    output logic             tst_en,
    output logic [BUS_W-1:0] tst_din
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tst_clk <= 1'b0;
            tst_en  <= 1'b0;
            tst_din <= '0;
        end else if (enter) begin
            unique case (phase)
                ST_CLK_RISE: begin
                    tst_clk <= 1'b1;
                end
                ST_ADDR_SET: begin
                    tst_en  <= 1'b1;
                    tst_din <= addr;
                end
                ST_ADDR_FALL: begin
                    tst_clk <= 1'b0;
                end
                ST_DATA_SET: begin
                    tst_en  <= 1'b0;
                    tst_din <= data;
                end
                ST_DATA_RISE: begin
                    tst_clk <= 1'b1;
                end
                ST_IDLE, ST_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/phy_tst_xactor.sv
module phy_tst_xactor
    import phy_tst_pkg::*;
#(
    parameter int BUS_W   = 8,
    parameter int STAT_W  = 16,
    parameter int DWELL_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [BUS_W-1:0]   req_addr,
    input  logic [BUS_W-1:0]   req_data,
    input  logic               req_addr_only,
    input  logic [DWELL_W-1:0] step_len,
    input  logic [STAT_W-1:0]  tst_status,
    output logic               busy,
    output logic               ack,
    output logic [BUS_W-1:0]   rd_byte,
    output logic               tst_clk,
    output logic               tst_en,
    output logic [BUS_W-1:0]   tst_din
);
    localparam logic [BUS_W-1:0] SKIP_CODE = {BUS_W{1'b1}};
    localparam int               RET_LO    = STAT_W - BUS_W;

    tst_state_e         state_q, state_n;
    logic               accept;
    logic               enter;
    logic               expired;
    logic               skip_q;
    logic [BUS_W-1:0]   addr_q, data_q, rd_q;
    logic [DWELL_W-1:0] step_q, len_sel;
    logic               unused_status_lo;

    assign unused_status_lo = ^tst_status[RET_LO-1:0];
    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign enter   = (state_n != state_q);
    assign len_sel = accept ? step_len : step_q;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_n = ST_CLK_RISE;
            ST_CLK_RISE:  if (expired) state_n = ST_ADDR_SET;
            ST_ADDR_SET:  if (expired) state_n = ST_ADDR_FALL;
            ST_ADDR_FALL: if (expired) state_n = skip_q ? ST_DONE : ST_DATA_SET;
            ST_DATA_SET:  if (expired) state_n = ST_DATA_RISE;
            ST_DATA_RISE: if (expired) state_n = ST_DONE;
            ST_DONE:      state_n = ST_IDLE;
            default:      state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            skip_q  <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            step_q  <= '0;
            rd_q    <= '0;
        end else begin
            state_q <= state_n;
            if (accept) begin
                skip_q <= req_addr_only || (req_data == SKIP_CODE);
                addr_q <= req_addr;
                data_q <= req_data;
                step_q <= step_len;
            end
            if (enter && state_n == ST_DONE) begin
                rd_q <= tst_status[STAT_W-1:RET_LO];
            end
        end
    end

    always_comb begin
        busy    = (state_q != ST_IDLE);
        ack     = (state_q == ST_DONE);
        rd_byte = rd_q;
    end

    phy_tst_dwell #(.DWELL_W(DWELL_W)) i_dwell (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (enter),
        .len     (len_sel),
        .expired (expired)
    );

    phy_tst_pins #(.BUS_W(BUS_W)) i_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .enter   (enter),
        .phase   (state_n),
        .addr    (addr_q),
        .data    (data_q),
        .tst_clk (tst_clk),
        .tst_en  (tst_en),
        .tst_din (tst_din)
    );
endmodule

// File: rtl/phy_tst_xactor_chk.sv
module phy_tst_xactor_chk #(
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             ack,
    input logic [BUS_W-1:0] rd_byte,
    input logic             tst_clk,
    input logic             tst_en,
    input logic [BUS_W-1:0] tst_din
);
    assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_ack_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> busy);

    assert_idle_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !busy);

    assert_fall_latches_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tst_clk) |-> (tst_en && $stable(tst_din)));

    assert_en_drop_clk_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tst_en) |-> !tst_clk);

    assert_rd_moves_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_byte != $past(rd_byte)) |-> ack);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> ($stable(tst_clk) && $stable(tst_en) && $stable(tst_din)));
endmodule

bind phy_tst_xactor phy_tst_xactor_chk #(.BUS_W(BUS_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .ack     (ack),
    .rd_byte (rd_byte),
    .tst_clk (tst_clk),
    .tst_en  (tst_en),
    .tst_din (tst_din)
);

// File: tb/test_phy_tst_xactor.sv
module test_phy_tst_xactor;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {addr, data, addr_only, step, status}
    localparam logic [36:0] VEC [NVEC] = '{
        {8'h34, 8'h15, 1'b0, 4'd1, 16'hA55A},
        {8'h44, 8'h2C, 1'b0, 4'd2, 16'h3C00},
        {8'h54, 8'hFF, 1'b0, 4'd1, 16'h7E11},
        {8'h84, 8'h12, 1'b1, 4'd3, 16'h0081},
        {8'h94, 8'h2C, 1'b0, 4'd0, 16'hFF00},
        {8'h00, 8'hFF, 1'b0, 4'd4, 16'h1234}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic       req_addr_only = 1'b0;
    logic [3:0] step_len = '0;
    logic [15:0] tst_status = '0;
    logic       busy, ack, tst_clk, tst_en;
    logic [7:0] rd_byte, tst_din;

    int checks = 0;
    int failures = 0;
    logic       prev_en = 1'b0;
    logic [7:0] prev_din = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_tst_xactor i_phy_tst_xactor (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_addr_only(req_addr_only), .step_len(step_len),
        .tst_status(tst_status), .busy(busy), .ack(ack), .rd_byte(rd_byte),
        .tst_clk(tst_clk), .tst_en(tst_en), .tst_din(tst_din)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_access(input logic [7:0] a, input logic [7:0] d, input logic ao,
                             input logic [3:0] st, input logic [15:0] stat, input logic poke);
        int eff;
        int p;
        int last;
        int ph;
        logic       e_clk, e_en;
        logic [7:0] e_din;
        string tag;
        eff  = (st == 0) ? 1 : int'(st);
        p    = (ao || d == 8'hFF) ? 3 : 5;
        last = p * eff + 1;
        @(negedge clk);
        req_addr = a; req_data = d; req_addr_only = ao; step_len = st;
        tst_status = stat; req_valid = 1'b1;
        for (int k = 1; k <= last + 1; k++) begin
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            if (poke && k == 2) begin
                req_valid = 1'b1; req_addr = 8'h5A; req_data = 8'h00;
                req_addr_only = 1'b0; step_len = 4'd7;
            end
            if (poke && k == 3) req_valid = 1'b0;
            ph = (k <= p * eff) ? (k - 1) / eff : p - 1;
            unique case (ph)
                0: begin e_clk = 1'b1; e_en = prev_en; e_din = prev_din; tag = "R2 first phase"; end
                1: begin e_clk = 1'b1; e_en = 1'b1; e_din = a; tag = "R3 address set"; end
                2: begin e_clk = 1'b0; e_en = 1'b1; e_din = a; tag = (p == 3 && k > p * eff) ? "R5 ends clock low" : "R3 address fall"; end
                3: begin e_clk = 1'b0; e_en = 1'b0; e_din = d; tag = "R4 data set"; end
                default: begin e_clk = 1'b1; e_en = 1'b0; e_din = d; tag = "R4 data rise"; end
            endcase
            if (poke) tag = {tag, " R9 busy request"};
            check(tst_clk == e_clk, {tag, " clk"}, 32'(tst_clk), 32'(e_clk));
            check(tst_en == e_en, {tag, " en"}, 32'(tst_en), 32'(e_en));
            check(tst_din == e_din, {tag, " din"}, 32'(tst_din), 32'(e_din));
            check(ack == (k == last), "R7 ack timing", 32'(ack), 32'(k == last));
            check(busy == (k <= last), "R8 busy span", 32'(busy), 32'(k <= last));
            if (k == last)
                check(rd_byte == stat[15:8], "R6 captured byte", 32'(rd_byte), 32'(stat[15:8]));
        end
        prev_en = (p == 3) ? 1'b1 : 1'b0;
        prev_din = (p == 3) ? a : d;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(tst_clk == 1'b0, "R1 reset clk", 32'(tst_clk), 0);
        check(tst_en == 1'b0, "R1 reset en", 32'(tst_en), 0);
        check(tst_din == 8'h00, "R1 reset din", 32'(tst_din), 0);
        check(busy == 1'b0 && ack == 1'b0, "R1 reset busy/ack", {30'd0, busy, ack}, 0);
        check(rd_byte == 8'h00, "R1 reset captured byte", 32'(rd_byte), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            do_access(VEC[v][36:29], VEC[v][28:21], VEC[v][20], VEC[v][19:16], VEC[v][15:0], 1'b0);
        end

        // R9/R7: request and step change while busy are ignored
        do_access(8'h64, 8'h3B, 1'b0, 4'd2, 16'hC3F0, 1'b1);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R9 no extra access", 32'(busy), 0);
        check(tst_din == 8'h3B, "R9 pins held", 32'(tst_din), 32'h3B);

        // R6: captured byte holds while status moves
        tst_status = 16'h9999;
        repeat (4) @(negedge clk);
        check(rd_byte == 8'hC3, "R6 byte held", 32'(rd_byte), 32'hC3);

        // R5: address-only with a normal data byte, then a write starting with en high
        do_access(8'hB4, 8'h00, 1'b1, 4'd1, 16'h4200, 1'b0);
        do_access(8'h44, 8'h06, 1'b0, 4'd3, 16'h0F00, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule